// File: doc/BRIEF.md
# Local Interrupt Timer with Countdown and Timestamp-Deadline Modes

This block is the timer of a processor's local interrupt controller. Software programs a timer entry that holds the interrupt vector, a mask bit and a mode field. In countdown mode, writing a nonzero start value loads a down-counter. The counter is clocked by a programmable power-of-two divider that runs off a tick-enable input, and the block raises one interrupt request when the count runs out. In deadline mode, software writes an absolute 64-bit target. The block compares it every cycle against a free-running timestamp input, fires as soon as the timestamp is at or beyond the target, and then clears the target itself.

Each expiry that is not masked produces a one-cycle request pulse, presents the programmed vector, and sets a pending flag that stays set until the acknowledge input clears it. Registers are written through a single write port and read through a combinational read port.

Top module: `local_irq_timer`

## Requirements
- R1: After reset, irq_pulse and irq_pending are 0, and the timer entry (address 0), divide (1), start count (2), current count (3) and deadline (4) registers all read 0.
- R2: Timer entry layout: vector in bits [7:0], mask in bit 16, mode in bits [18:17] (2'b10 = deadline, any other value = countdown). irq_vector shows the vector that was programmed when the request was raised.
- R3: The divider is chosen by bits {3,1,0} of the divide register: 3'b111 divides by 1, and every other value k divides by 2^(k+1) (so 0xB gives /1 and 0xA gives /128).
- R4: In countdown mode, writing a nonzero start count N raises exactly one irq_pulse, one cycle wide, seen in the cycle after the (N x divisor)-th tick edge that follows the write.
- R5: The current-count register reads the remaining count, falls by one on each divided tick, and holds 0 after expiry.
- R6: Writing a start count of 0 stops a running countdown with no request.
- R7: In deadline mode, a nonzero deadline fires at the first clock edge where tsc >= deadline. A deadline that is already in the past when written fires on the edge after the write.
- R8: The deadline register reads 0 after it fires. Writing 0 disarms it with no request.
- R9: With the mask bit set, an expiry still completes (the count reaches 0 and the deadline clears) but gives no irq_pulse and no pending.
- R10: Start-count writes are ignored in deadline mode, and deadline writes are ignored in countdown mode.
- R11: irq_pending is set by each irq_pulse and is cleared by irq_ack. If a new request and irq_ack fall in the same cycle, the request wins.
- R12: Any change of the mode field stops the countdown and disarms the deadline.
- R13: The countdown advances only on cycles where tmr_tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_tick | input | 1 | Timer input tick enable |
| tsc | input | 64 | Free-running timestamp counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| irq_ack | input | 1 | Clears the pending flag |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_pending | output | 1 | Request pending until acknowledged |
| irq_vector | output | 8 | Vector of the last request |

## Verification
A new expiry and the acknowledge of an older request can land on the same clock edge. In that case the pending flag must stay set, because setting it takes priority over clearing it. The bench leaves a request pending, arms a deadline that is already in the past, and holds irq_ack through the edge where that deadline fires. It expects both a pulse and a set pending flag on that edge, and expects the flag to drop only on the next edge, where only the acknowledge is active. The countdown is also checked against its mode: a start-count write must not take effect while in deadline mode, and a mode change must cancel a running countdown.

// File: rtl/lit_pkg.sv
`timescale 1ns/1ps
// Shared register map and timer-entry layout for the local interrupt timer.
package lit_pkg;
    localparam int ADDR_W        = 3;
    localparam int VEC_W         = 8;
    localparam int LVT_MASK_BIT  = 16;
    localparam int LVT_MODE_LSB  = 17;

    typedef enum logic [ADDR_W-1:0] {
        REG_LVT   = 3'd0,
        REG_DIV   = 3'd1,
        REG_INIT  = 3'd2,
        REG_CUR   = 3'd3,
        REG_DLINE = 3'd4
    } reg_sel_e;

    localparam logic [1:0] MODE_DEADLINE = 2'b10;

    typedef struct packed {
        logic [1:0]       mode;
        logic             mask;
        logic [VEC_W-1:0] vec;
    } lvt_t;
endpackage

// File: rtl/lit_prescale.sv
`timescale 1ns/1ps
// Power-of-two tick divider. It emits one strobe per 'divisor' input ticks
// and restarts its phase when restart is high.
// Assumes PRE_W >= 7 so that the largest divisor (128) fits.
module lit_prescale #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       tick,
    input  logic [2:0] sel,
    output logic       strobe
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // Decode the select code into divisor-1.
    always_comb begin
        if (sel == 3'b111) begin
            limit = '0;
        end else begin
            limit = PRE_W'((32'd1 << (int'(sel) + 1)) - 32'd1);
        end
    end

    assign strobe = tick && (cnt_q >= limit);

    // Count input ticks and wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= strobe ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lit_countdown.sv
`timescale 1ns/1ps
// Down-counter for countdown mode. A nonzero count means it is running.
// expire is high in the cycle where the last unit is used up.
module lit_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    input  logic             strobe,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic [CNT_W-1:0] cur_q;

    assign cur    = cur_q;
    assign expire = strobe && (cur_q == CNT_W'(1));

    // Load, cancel or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= load_val;
        end else if (strobe && (cur_q != '0)) begin
            cur_q <= cur_q - 1'b1;
        end
    end
endmodule

// File: rtl/lit_deadline.sv
`timescale 1ns/1ps
// Absolute timestamp comparator. A nonzero target is armed. It fires once
// the timestamp is at or beyond the target, then clears itself. A write in
// the same cycle takes precedence over a fire.
module lit_deadline #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    input  logic            clear,
    input  logic [TS_W-1:0] tsc,
    output logic [TS_W-1:0] target,
    output logic            fire
);
    logic [TS_W-1:0] tgt_q;

    assign target = tgt_q;
    assign fire   = !load && !clear && (tgt_q != '0) && (tsc >= tgt_q);

    // Hold, replace or self-clear the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tgt_q <= '0;
        end else if (load) begin
            tgt_q <= load_val;
        end else if (fire) begin
            tgt_q <= '0;
        end
    end
endmodule

// File: rtl/local_irq_timer.sv
`timescale 1ns/1ps
// Local interrupt timer top: register file, mode steering and request
// generation. Assumes CNT_W <= DATA_W and TS_W == DATA_W.
module local_irq_timer #(
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64,
    parameter int DATA_W = 64,
    parameter int PRE_W  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tmr_tick,
    input  logic [TS_W-1:0]           tsc,
    input  logic                      wr_en,
    input  logic [lit_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [lit_pkg::ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      irq_ack,
    output logic                      irq_pulse,
    output logic                      irq_pending,
    output logic [lit_pkg::VEC_W-1:0] irq_vector
);
    import lit_pkg::*;

    lvt_t              lvt_q;
    logic [3:0]        div_q;
    logic [CNT_W-1:0]  init_q;
    logic              wr_lvt, wr_div, wr_init, wr_dl;
    logic              mode_dl, mode_chg, cfg_mask;
    logic              os_load, dl_load, strobe, os_expire, dl_fire;
    logic              deliver;
    logic [CNT_W-1:0]  cur_cnt;
    logic [TS_W-1:0]   dl_val;
    logic              pulse_q, pend_q;
    logic [VEC_W-1:0]  vec_q;

    assign wr_lvt   = wr_en && (wr_addr == REG_LVT);
    assign wr_div   = wr_en && (wr_addr == REG_DIV);
    assign wr_init  = wr_en && (wr_addr == REG_INIT);
    assign wr_dl    = wr_en && (wr_addr == REG_DLINE);
    assign mode_dl  = (lvt_q.mode == MODE_DEADLINE);
    assign cfg_mask = lvt_q.mask;
    assign mode_chg = wr_lvt && (wr_data[LVT_MODE_LSB +: 2] != lvt_q.mode);
    assign os_load  = wr_init && !mode_dl;
    assign dl_load  = wr_dl && mode_dl;

    // Configuration registers: timer entry, divide code and start count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvt_q  <= '0;
            div_q  <= '0;
            init_q <= '0;
        end else begin
            if (wr_lvt) begin
                lvt_q.mode <= wr_data[LVT_MODE_LSB +: 2];
                lvt_q.mask <= wr_data[LVT_MASK_BIT];
                lvt_q.vec  <= wr_data[VEC_W-1:0];
            end
            if (wr_div) begin
                div_q <= {wr_data[3], 1'b0, wr_data[1:0]};
            end
            if (os_load) begin
                init_q <= wr_data[CNT_W-1:0];
            end
        end
    end

    lit_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (os_load),
        .tick    (tmr_tick),
        .sel     ({div_q[3], div_q[1:0]}),
        .strobe  (strobe)
    );

    lit_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (os_load),
        .load_val (wr_data[CNT_W-1:0]),
        .stop     (mode_chg),
        .strobe   (strobe),
        .cur      (cur_cnt),
        .expire   (os_expire)
    );

    lit_deadline #(.TS_W(TS_W)) u_dl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dl_load),
        .load_val (wr_data[TS_W-1:0]),
        .clear    (mode_chg),
        .tsc      (tsc),
        .target   (dl_val),
        .fire     (dl_fire)
    );

    assign deliver = (os_expire || dl_fire) && !cfg_mask;

    // Request pulse, pending flag (set wins over ack) and latched vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pend_q  <= 1'b0;
            vec_q   <= '0;
        end else begin
            pulse_q <= deliver;
            if (deliver) begin
                pend_q <= 1'b1;
                vec_q  <= lvt_q.vec;
            end else if (irq_ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign irq_pulse   = pulse_q;
    assign irq_pending = pend_q;
    assign irq_vector  = vec_q;

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_LVT: begin
                rd_data[VEC_W-1:0]          = lvt_q.vec;
                rd_data[LVT_MASK_BIT]       = lvt_q.mask;
                rd_data[LVT_MODE_LSB +: 2]  = lvt_q.mode;
            end
            REG_DIV:   rd_data[3:0] = div_q;
            REG_INIT:  rd_data = DATA_W'(init_q);
            REG_CUR:   rd_data = DATA_W'(cur_cnt);
            REG_DLINE: rd_data = DATA_W'(dl_val);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/local_irq_timer_chk.sv
`timescale 1ns/1ps
// Property checker for local_irq_timer, bound to every instance.
module local_irq_timer_chk #(
    parameter int CNT_W = 32,
    parameter int TS_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_pulse,
    input logic             irq_pending,
    input logic             irq_ack,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             cfg_mask,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [TS_W-1:0]  dl_val
);
    logic init_wr;
    assign init_wr = wr_en && (wr_addr == lit_pkg::REG_INIT);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse); // R4
    AST_PULSE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_pending); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && irq_ack) |=> (!irq_pending || irq_pulse)); // R11
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(cfg_mask)); // R9
    AST_CUR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(init_wr) |-> (cur_cnt <= $past(cur_cnt))); // R5
    AST_EXPIRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (cur_cnt == '0 && dl_val == '0)); // R8
endmodule

bind local_irq_timer local_irq_timer_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pulse   (irq_pulse),
    .irq_pending (irq_pending),
    .irq_ack     (irq_ack),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .cfg_mask    (cfg_mask),
    .cur_cnt     (cur_cnt),
    .dl_val      (dl_val)
);

// File: tb/local_irq_timer_tb_top.sv
`timescale 1ns/1ps
module local_irq_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_tick = 1'b1;
    logic [63:0] tsc = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        irq_ack = 1'b0;
    logic        irq_pulse, irq_pending;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Countdown table: {divide code[27:24], start count[23:8], vector[7:0]}
    localparam logic [27:0] OS_TAB [0:8] = '{
        {4'hB, 16'd5, 8'h31}, {4'h0, 16'd3, 8'h32}, {4'h1, 16'd2, 8'h33},
        {4'h2, 16'd4, 8'h34}, {4'h3, 16'd1, 8'h35}, {4'h8, 16'd1, 8'h36},
        {4'h9, 16'd1, 8'h37}, {4'hA, 16'd1, 8'h38}, {4'hB, 16'd1, 8'h39}
    };

    always #2.5 clk = ~clk;

    local_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .tsc(tsc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_ack(irq_ack),
        .irq_pulse(irq_pulse), .irq_pending(irq_pending), .irq_vector(irq_vector)
    );

    function automatic int div_of(input logic [3:0] c);
        logic [2:0] k;
        k = {c[3], c[1], c[0]};
        if (k == 3'b111) return 1;
        return 2 << int'(k);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // Watch for any pulse over n cycles; returns 1 if one was seen.
    task automatic quiet(input int n, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq_pulse) seen = 1'b1;
        end
    endtask

    initial begin : main
        logic [63:0] v;
        bit seen;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pulse", {63'b0, irq_pulse}, 64'd0);
        chk("R1 pending", {63'b0, irq_pending}, 64'd0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 register", v, 64'd0);
        end

        // Table walk: R3 divide, R4 timing, R2 vector, R11 ack, R5 hold
        for (int i = 0; i < 9; i++) begin
            logic [3:0] dc;
            logic [15:0] ic;
            logic [7:0] vc;
            {dc, ic, vc} = OS_TAB[i];
            wr(3'd0, {56'b0, vc});
            wr(3'd1, {60'b0, dc});
            wr(3'd2, {48'b0, ic});
            n = 0;
            while (!irq_pulse && n < 400) begin
                @(negedge clk);
                n++;
            end
            chk("R3 R4 expiry cycle", 64'(n), 64'(int'(ic) * div_of(dc)));
            chk("R2 vector", {56'b0, irq_vector}, {56'b0, vc});
            chk("R11 pending set", {63'b0, irq_pending}, 64'd1);
            irq_ack = 1'b1;
            @(negedge clk);
            irq_ack = 1'b0;
            chk("R4 single-cycle pulse", {63'b0, irq_pulse}, 64'd0);
            chk("R11 ack clears", {63'b0, irq_pending}, 64'd0);
            quiet(4, seen);
            chk("R4 exactly one request", {63'b0, seen}, 64'd0);
            rd(3'd3, v);
            chk("R5 current count holds zero", v, 64'd0);
        end

        // R5 remaining count mid-run, /1
        wr(3'd1, 64'hB);
        wr(3'd2, 64'd10);
        repeat (3) @(negedge clk);
        rd(3'd3, v);
        chk("R5 remaining count", v, 64'd7);
        // R6 start count 0 stops
        wr(3'd2, 64'd0);
        quiet(20, seen);
        chk("R6 no request after stop", {63'b0, seen}, 64'd0);
        rd(3'd3, v);
        chk("R6 count cleared", v, 64'd0);

        // R9 masked expiry completes silently
        wr(3'd0, 64'h0001_0055);
        wr(3'd2, 64'd3);
        quiet(10, seen);
        chk("R9 masked no pulse", {63'b0, seen}, 64'd0);
        chk("R9 masked no pending", {63'b0, irq_pending}, 64'd0);
        rd(3'd3, v);
        chk("R9 masked count done", v, 64'd0);

        // R13 tick gating
        wr(3'd0, 64'h0000_0056);
        tmr_tick = 1'b0;
        wr(3'd2, 64'd7);
        quiet(10, seen);
        chk("R13 no progress without tick", {63'b0, seen}, 64'd0);
        rd(3'd3, v);
        chk("R13 count frozen", v, 64'd7);
        tmr_tick = 1'b1;
        n = 0;
        while (!irq_pulse && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R13 resumes", 64'(n), 64'd7);

        // R12 mode change cancels countdown
        wr(3'd2, 64'd100);
        wr(3'd0, 64'h0004_0060);
        rd(3'd3, v);
        chk("R12 countdown cancelled", v, 64'd0);
        // R10 start-count write ignored in deadline mode
        wr(3'd2, 64'd3);
        quiet(120, seen);
        chk("R10 init ignored no pulse", {63'b0, seen}, 64'd0);
        rd(3'd3, v);
        chk("R10 init ignored count", v, 64'd0);

        // R7 deadline reached
        @(negedge clk); tsc = 64'd1000;
        wr(3'd4, 64'd1010);
        quiet(3, seen);
        chk("R7 not early", {63'b0, seen}, 64'd0);
        tsc = 64'd1009;
        @(negedge clk);
        chk("R7 not at target-1", {63'b0, irq_pulse}, 64'd0);
        tsc = 64'd1010;
        @(negedge clk);
        chk("R7 fires at target", {63'b0, irq_pulse}, 64'd1);
        chk("R2 deadline vector", {56'b0, irq_vector}, 64'h60);
        rd(3'd4, v);
        chk("R8 deadline self-clears", v, 64'd0);

        // R7 past deadline fires on the next edge
        tsc = 64'd5000;
        wr(3'd4, 64'd100);
        chk("R7 past not yet", {63'b0, irq_pulse}, 64'd0);
        @(negedge clk);
        chk("R7 past fires", {63'b0, irq_pulse}, 64'd1);

        // R11 coincidence: ack held while a new deadline fires
        wr(3'd4, 64'd50);
        irq_ack = 1'b1;
        @(negedge clk);
        chk("R11 request beats ack pulse", {63'b0, irq_pulse}, 64'd1);
        chk("R11 request beats ack pending", {63'b0, irq_pending}, 64'd1);
        @(negedge clk);
        chk("R11 ack alone clears", {63'b0, irq_pending}, 64'd0);
        irq_ack = 1'b0;

        // R8 writing zero disarms
        tsc = 64'd1500;
        wr(3'd4, 64'd2000);
        wr(3'd4, 64'd0);
        tsc = 64'd3000;
        quiet(5, seen);
        chk("R8 disarmed no pulse", {63'b0, seen}, 64'd0);

        // R12 mode change disarms deadline
        wr(3'd4, 64'd9999);
        rd(3'd4, v);
        chk("R12 deadline armed", v, 64'd9999);
        wr(3'd0, 64'h0000_0061);
        rd(3'd4, v);
        chk("R12 deadline disarmed", v, 64'd0);
        // R10 deadline write ignored in countdown mode
        wr(3'd4, 64'd1);
        quiet(5, seen);
        chk("R10 deadline ignored no pulse", {63'b0, seen}, 64'd0);
        rd(3'd4, v);
        chk("R10 deadline ignored reg", v, 64'd0);
        rd(3'd0, v);
        chk("R2 entry readback", v, 64'h61);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule